// File: doc/BRIEF.md
# Serial Receive Buffer with Handshake-Cleared Status

This block is the receive half of an asynchronous serial port. The incoming line passes through a synchronizer and is sampled on a 16x oversampling strobe. A receive state machine assembles frames of one start bit, eight data bits sent LSB first and one stop bit. Each frame that ends cleanly is copied into a holding register, and a "data ready" flag is raised.

Software reaches the block through a small register bus with two addresses. Address 0 returns the held byte and is read-only. Address 1 returns three status flags: data ready, overrun and framing error. A flag can only be cleared by a two-step handshake. Software first reads the flag as 1, then writes 0 to that bit.

The held byte and the ready flag do not change when a frame has a bad stop bit or when the receiver is switched off. A frame that completes while earlier data is still unclaimed is dropped and recorded as an overrun. The strobe generator sits outside the block and drives `os_tick`.

Top module: `serial_rx_buffer`

## Requirements
- R1: After synchronous reset the status register (address 1) reads 0 and the held byte (address 0) reads 0x00.
- R2: A frame with a high stop bit, received while data ready (status bit 0) and overrun (status bit 1) are both 0, is copied to address 0 and sets data ready. The frame is 16 ticks per bit, one low start bit, eight data bits LSB first, then the stop bit.
- R3: A flag is armed when a status read returns it as 1. Any status write disarms all flags. A written 0 clears a flag only if that flag is armed, so a 0 written to an unarmed flag leaves it set.
- R4: Writing 1 to a status bit never changes that flag.
- R5: A clean frame that completes while data ready is 1 sets overrun. The held byte and data ready keep their values.
- R6: While overrun is 1, a clean frame is not copied to address 0 even when data ready is 0, and data ready stays 0.
- R7: A frame whose stop bit is sampled low sets the framing flag (status bit 2). It leaves the held byte and data ready unchanged.
- R8: A low pulse on the line shorter than half a bit fails the majority vote of three mid-bit samples. It produces no frame, and the next real frame is received correctly.
- R9: While receive enable is 0 the line is ignored and no flag or data changes. Dropping receive enable, including in the middle of a frame, leaves the held byte and data ready as they were.
- R10: Asserting standby forces data ready to 0 and leaves the held byte unchanged.
- R11: The overrun and framing flags are cleared only by the same read-1-then-write-0 handshake.
- R12: If a clearing write to data ready lands in the same cycle as a clean frame completing, the frame is judged against the flag's value before the write. Overrun is set, data ready is cleared and the held byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Forces data ready to 0 while high |
| rx_en | input | 1 | Receive enable; 0 holds the receiver idle |
| os_tick | input | 1 | 16x oversampling strobe |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = held byte, 1 = status |
| bus_wdata | input | 3 | Status write data (bit0 ready, bit1 overrun, bit2 framing) |
| bus_rdata | output | 8 | Read data for the addressed register |

## Verification
A clearing write to data ready can land in the same clock edge as a clean frame completing. The write must be checked against the flag value before the edge.

The bench first arms the flag with a status read. It then starts a frame and, in a forked branch, counts clock cycles from the start bit. It issues the 0-write so that it lands on the edge where the stop-bit result is taken.

The outcome is judged at the ports: ready cleared, overrun set, and the earlier byte still held. This exposes any design that lets the clear win first and then accepts the frame as fresh data.

// File: rtl/rxs_pkg.sv
// Shared constants and types for the serial receive buffer.
// Assumes one status register holding three flags in the bit positions below.
package rxs_pkg;
    localparam int ST_N    = 3;     // number of status flags
    localparam int ST_FULL = 0;     // data ready flag position
    localparam int ST_OVR  = 1;     // overrun flag position
    localparam int ST_FE   = 2;     // framing error flag position
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rxs_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module rxs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    // shift the raw line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rxs_frame.sv
// Receive state machine: start-bit vote, data assembly, stop-bit check.
// Assumes os_tick is a strobe at OS_RATE times the bit rate and rx_s is synchronous.
// Emits a one-cycle done pulse with a framing flag; data_o is valid with it.
module rxs_frame
    import rxs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              rx_s,
    output logic              done,
    output logic              ferr,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OS_RATE / 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] VOTE_LO  = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] VOTE_HI  = CNT_W'(OS_RATE / 2 + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        votes_q;
    logic [1:0]        lows_now;
    logic [DATA_W-1:0] shreg_q;
    logic              done_q;
    logic              ferr_q;

    // count of low samples including the current one
    always_comb lows_now = votes_q + {1'b0, ~rx_s};

    // bit timing, sampling and frame sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            votes_q <= '0;
            shreg_q <= '0;
            done_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!rx_en) begin
                state_q <= RX_IDLE;
                cnt_q   <= '0;
            end else if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                            votes_q <= '0;
                        end
                    end
                    RX_START: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q >= VOTE_LO && cnt_q <= VOTE_HI)
                            votes_q <= lows_now;
                        if (cnt_q == VOTE_HI && lows_now < 2'd2) begin
                            state_q <= RX_IDLE;
                            cnt_q   <= '0;
                        end else if (cnt_q == CNT_LAST) begin
                            state_q <= RX_DATA;
                            cnt_q   <= '0;
                            idx_q   <= '0;
                        end
                    end
                    RX_DATA: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_MID)
                            shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
                        if (cnt_q == CNT_LAST) begin
                            cnt_q <= '0;
                            if (idx_q == IDX_LAST) state_q <= RX_STOP;
                            else                   idx_q   <= idx_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_MID) begin
                            done_q  <= 1'b1;
                            ferr_q  <= ~rx_s;
                            state_q <= RX_IDLE;
                            cnt_q   <= '0;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign done   = done_q;
    assign ferr   = ferr_q;
    assign data_o = shreg_q;

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == RX_IDLE && !done_q));

    // R8
    start_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && tick && rx_en && cnt_q == VOTE_HI && lows_now < 2'd2)
        |=> state_q == RX_IDLE);
endmodule

// File: rtl/rxs_status.sv
// Holding register, status flags and register-bus decode.
// Flags clear only through a read-1 then write-0 handshake tracked by per-flag arm bits.
// Assumes at most one bus access per cycle and a single-cycle done pulse from the framer.
module rxs_status
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              frame_done,
    input  logic              frame_ferr,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [ST_N-1:0]   bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DATA_W-1:0] hold_q;
    logic [ST_N-1:0]   flag_q;
    logic [ST_N-1:0]   arm_q;
    logic [ST_N-1:0]   clr;
    logic              stat_rd;
    logic              stat_wr;
    logic              good;
    logic              load;

    // bus decode and frame outcome
    always_comb begin
        stat_rd = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
        stat_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_STAT);
        clr     = {ST_N{stat_wr}} & ~bus_wdata & arm_q;
        good    = frame_done && !frame_ferr;
        load    = good && !flag_q[ST_FULL] && !flag_q[ST_OVR];
    end

    // per-flag arm latch: set by a read of 1, dropped by any status write
    for (genvar gi = 0; gi < ST_N; gi++) begin : g_arm
        always_ff @(posedge clk) begin
            if (!rst_n)                               arm_q[gi] <= 1'b0;
            else if (stat_wr)                         arm_q[gi] <= 1'b0;
            else if (gi == ST_FULL && standby)        arm_q[gi] <= 1'b0;
            else if (stat_rd && flag_q[gi])           arm_q[gi] <= 1'b1;
        end
    end

    // holding register: written only by an accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= frame_data;
    end

    // data ready flag: standby first, then set, then handshake clear
    always_ff @(posedge clk) begin
        if (!rst_n)            flag_q[ST_FULL] <= 1'b0;
        else if (standby)      flag_q[ST_FULL] <= 1'b0;
        else if (load)         flag_q[ST_FULL] <= 1'b1;
        else if (clr[ST_FULL]) flag_q[ST_FULL] <= 1'b0;
    end

    // overrun flag: set when a clean frame meets unclaimed data
    always_ff @(posedge clk) begin
        if (!rst_n)                         flag_q[ST_OVR] <= 1'b0;
        else if (good && flag_q[ST_FULL])   flag_q[ST_OVR] <= 1'b1;
        else if (clr[ST_OVR])               flag_q[ST_OVR] <= 1'b0;
    end

    // framing error flag: set on a low stop bit
    always_ff @(posedge clk) begin
        if (!rst_n)                         flag_q[ST_FE] <= 1'b0;
        else if (frame_done && frame_ferr)  flag_q[ST_FE] <= 1'b1;
        else if (clr[ST_FE])                flag_q[ST_FE] <= 1'b0;
    end

    // read mux
    always_comb begin
        if (bus_addr == ADDR_DATA) bus_rdata = hold_q;
        else                       bus_rdata = DATA_W'(flag_q);
    end

    // R2
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[ST_FULL]) |-> $past(frame_done && !frame_ferr));

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_ferr && flag_q[ST_FULL]) |=> (flag_q[ST_OVR] && $stable(hold_q)));

    // R7
    ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_ferr) |=> (flag_q[ST_FE] && $stable(hold_q)));

    // R10
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !flag_q[ST_FULL]);

    // R3
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (arm_q == '0));

    // R4
    write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata[ST_FULL] && flag_q[ST_FULL] && !standby) |=> flag_q[ST_FULL]);
endmodule

// File: rtl/serial_rx_buffer.sv
// Top level: synchronizer, receive state machine and status/holding registers.
// Assumes os_tick is supplied by an external baud strobe generator.
module serial_rx_buffer
    import rxs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [ST_N-1:0]   bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              rx_s;
    logic              f_done;
    logic              f_ferr;
    logic [DATA_W-1:0] f_data;

    rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .d_out (rx_s)
    );

    rxs_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (rx_en),
        .tick   (os_tick),
        .rx_s   (rx_s),
        .done   (f_done),
        .ferr   (f_ferr),
        .data_o (f_data)
    );

    rxs_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .frame_done (f_done),
        .frame_ferr (f_ferr),
        .frame_data (f_data),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: tb/sim_serial_rx_buffer.sv
// Scoreboard bench: stimulus pushes expected register contents, the monitor task pops and compares.
module sim_serial_rx_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       rx_en = 1'b1;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [2:0] bus_wdata = 3'b0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] data;
        logic [2:0] stat;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    serial_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .rx_en(rx_en),
        .os_tick(os_tick), .rx_in(rx_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: one frame, 16 clocks per bit (os_tick held high)
    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (16) @(negedge clk);
        end
        rx_in = stop_bit;
        repeat (16) @(negedge clk);
        rx_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] d, input logic [2:0] s, input string req);
        exp_t e;
        e.data = d; e.stat = s; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: pop the oldest expectation and compare both registers (status read arms flags)
    task automatic monitor_check();
        exp_t e;
        logic [7:0] d, s;
        e = sb_q.pop_front();
        bus_read(1'b0, d);
        check(d == e.data, {e.req, " data"}, d, e.data);
        bus_read(1'b1, s);
        check(s == {5'b0, e.stat}, {e.req, " status"}, s, {5'b0, e.stat});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        push_exp(8'h00, 3'b000, "R1"); monitor_check();

        // R2 clean frame
        send_frame(8'hA5, 1'b1);
        push_exp(8'hA5, 3'b001, "R2"); monitor_check();

        // R4 write ones: no change (also disarms)
        bus_write(3'b111);
        push_exp(8'hA5, 3'b001, "R4"); monitor_check();
        // R3 unarmed zero write ignored
        bus_write(3'b111);
        bus_write(3'b000);
        push_exp(8'hA5, 3'b001, "R3 unarmed"); monitor_check();
        // R3 armed zero write clears
        bus_write(3'b000);
        push_exp(8'hA5, 3'b000, "R3 armed"); monitor_check();

        // R5 overrun
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        push_exp(8'h11, 3'b011, "R5"); monitor_check();
        // R11 overrun cleared by handshake
        bus_write(3'b000);
        push_exp(8'h11, 3'b000, "R11 overrun"); monitor_check();

        // R6 no transfer while overrun set
        send_frame(8'h44, 1'b1);
        send_frame(8'h55, 1'b1);
        push_exp(8'h44, 3'b011, "R6 setup"); monitor_check();
        bus_write(3'b010);
        push_exp(8'h44, 3'b010, "R6 ready only"); monitor_check();
        bus_write(3'b111);
        send_frame(8'h66, 1'b1);
        push_exp(8'h44, 3'b010, "R6"); monitor_check();
        bus_write(3'b000);
        push_exp(8'h44, 3'b000, "R6 clear"); monitor_check();

        // R7 framing error
        send_frame(8'h77, 1'b0);
        push_exp(8'h44, 3'b100, "R7"); monitor_check();
        send_frame(8'h88, 1'b1);
        push_exp(8'h88, 3'b101, "R7 next"); monitor_check();
        // R11 framing flag cleared by handshake
        bus_write(3'b000);
        push_exp(8'h88, 3'b000, "R11 framing"); monitor_check();

        // R8 short glitch rejected
        @(negedge clk);
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (100) @(negedge clk);
        push_exp(8'h88, 3'b000, "R8 glitch"); monitor_check();
        send_frame(8'h99, 1'b1);
        push_exp(8'h99, 3'b001, "R8 recover"); monitor_check();

        // R9 disabled receiver ignores the line
        rx_en = 1'b0;
        send_frame(8'hAA, 1'b1);
        push_exp(8'h99, 3'b001, "R9 off"); monitor_check();
        bus_write(3'b000);
        rx_en = 1'b1;
        fork
            send_frame(8'hBB, 1'b1);
            begin repeat (60) @(negedge clk); rx_en = 1'b0; end
        join
        rx_en = 1'b1;
        push_exp(8'h99, 3'b000, "R9 midframe"); monitor_check();
        send_frame(8'hCC, 1'b1);
        rx_en = 1'b0;
        repeat (10) @(negedge clk);
        push_exp(8'hCC, 3'b001, "R9 disable keeps"); monitor_check();
        rx_en = 1'b1;

        // R10 standby
        @(negedge clk); standby = 1'b1;
        repeat (3) @(negedge clk); standby = 1'b0;
        push_exp(8'hCC, 3'b000, "R10"); monitor_check();

        // R12 clear and completion in the same cycle
        send_frame(8'hDD, 1'b1);
        push_exp(8'hDD, 3'b001, "R12 setup"); monitor_check();
        fork
            send_frame(8'hEE, 1'b1);
            begin
                @(negedge clk);
                repeat (156) @(negedge clk);
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 3'b000;
                @(negedge clk);
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
        join
        push_exp(8'hDD, 3'b010, "R12"); monitor_check();
        bus_write(3'b000);
        push_exp(8'hDD, 3'b000, "R12 clear"); monitor_check();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule